// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Programmable Frame Format

This block turns bytes written by a host into asynchronous serial frames on a single output line. A host checks the holding-empty flag, writes a byte, and the block moves it into a shift register as soon as the shifter is free. It sends a low start bit, the data bits least-significant first, an optional parity bit and one or two high stop bits. A programmable 16-bit divisor divides the reference clock into a tick at sixteen times the bit rate, so each serial bit lasts sixteen ticks.

The frame format comes from a set of format inputs: the data length (5 to 8 bits), the stop count, parity enable, parity sense, and a stick mode that sends a constant parity bit. A break input holds the line low for as long as it is set. The block samples the format at the moment a byte enters the shifter, so a format change made during a frame applies from the next frame. A byte written while a frame is running waits in the holding register and starts right after the last stop bit, with no idle gap.

Two flags report progress. One shows that the holding register can take a byte. The other shows that the holding register and the shifter are both empty, so all written data has left the line.

Top module: `sertx_top`

## Requirements
- R1: After reset the line is high (1), the holding-empty flag is 1 and the idle flag is 1.
- R2: A write sets the holding register full on the next clock edge (hold_empty = 0). If the shifter is idle, the byte moves into the shifter on the following edge: hold_empty returns to 1, tx_idle is 0 and the start bit begins.
- R3: A frame is a low start bit, then the data bits least-significant bit first, then the parity bit if enabled, then the stop bits at 1. Each bit lasts 16 x divisor reference cycles, and a divisor of 0 acts as 1.
- R4: The length code cfg_len_sel gives the data bit count: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8.
- R5: cfg_two_stop = 0 sends one stop bit, and cfg_two_stop = 1 sends two.
- R6: With cfg_par_en = 1 and cfg_par_stick = 0, the parity bit is the XOR of the sent data bits when cfg_par_even = 1, and its inverse when cfg_par_even = 0.
- R7: With cfg_par_en = 1 and cfg_par_stick = 1, the parity bit is the constant NOT cfg_par_even, whatever the data.
- R8: While line_break is 1, txd is 0 in the same cycle, whatever the transmitter state. Clearing it gives the line back to the transmitter.
- R9: tx_idle is 1 only when the shifter is idle and the holding register is empty. After a load with nothing else pending, it returns to 1 exactly one frame length (bits x 16 x divisor cycles) after the load edge.
- R10: A byte written while a frame is in progress waits in the holding register. Its start bit begins in the cycle right after the last stop bit ends, and tx_idle stays 0 in between.
- R11: The format inputs are sampled when a byte enters the shifter. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| divisor | input | DIV_W | Reference cycles per tick (0 treated as 1) |
| cfg_len_sel | input | 2 | Data length code (5 + value bits) |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_par_en | input | 1 | 1 adds a parity bit |
| cfg_par_even | input | 1 | Parity sense, 1 = even |
| cfg_par_stick | input | 1 | 1 sends a constant parity bit |
| line_break | input | 1 | Forces the line low while set |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_idle | output | 1 | Holding register and shifter both empty |

## Verification
The checker watches, on every cycle, the properties that tie the flags and the line to one another: break drives the line low, an idle transmitter holds the line high, a write fills the holding register, idle implies an empty holding register, and every departure from idle is followed by a start bit. Bit order, bit duration, parity values, the length and stop encodings, back-to-back chaining with no gap, and the sampling of the format at load time can only be shown by the bench. It decodes whole frames at mid-bit points and compares them with frames computed arithmetically across every format combination and several divisors.

// File: rtl/sertx_pkg.sv
// Package: shared types and helpers for the serial transmitter.
// Assumes the data length code is 2 bits (5..8 data bits).
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       two_stop;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } frame_cfg_t;

    // Clears the data bits above the selected length.
    function automatic logic [7:0] keep_bits(input logic [7:0] d, input logic [1:0] sel);
        logic [7:0] m;
        m = 8'hFF >> (2'd3 - sel);
        return d & m;
    endfunction

    // Parity bit for already-masked data under a given format.
    function automatic logic parity_of(input logic [7:0] d, input frame_cfg_t c);
        if (c.par_stick)
            return ~c.par_even;
        else if (c.par_even)
            return ^d;
        else
            return ~(^d);
    endfunction

endpackage

// File: rtl/sertx_tick_gen.sv
// Tick generator: divides the reference clock by the divisor and pulses
// one cycle per period. A restart clears the phase so that the first bit of
// a frame is full length. A divisor of zero behaves as one.
module sertx_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             restart,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // Effective period, never zero.
    always_comb lim = (divisor == '0) ? DIV_W'(1) : divisor;

    // Tick on the last cycle of the period (>= covers a divisor cut mid-count).
    always_comb tick = (cnt >= lim - DIV_W'(1));

    // Phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || tick)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end

endmodule

// File: rtl/sertx_hold.sv
// Holding register: captures a written byte and keeps it until the shifter
// takes it. A write in the same cycle as a take refills the register, and
// the take consumes the old byte.
module sertx_hold (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       take,
    output logic       full,
    output logic [7:0] data
);

    // Full flag and byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_en) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/sertx_shifter.sv
// Frame shifter: loads a byte from the holding register, latches the format
// and sends start, data (LSB first), optional parity and stop bits, each
// OSR ticks long. It reloads at the end of the last stop bit when a byte is
// waiting, so consecutive frames touch.
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic       hold_full,
    input  logic [7:0] hold_data,
    output logic       load,
    output logic       line,
    output logic       busy
);

    localparam int SUB_W = (OSR > 1) ? $clog2(OSR) : 1;

    tx_state_e        state;
    logic [SUB_W-1:0] sub;
    logic [2:0]       bit_idx;
    logic             stop_idx;
    logic [7:0]       shreg;
    logic             par_q;
    frame_cfg_t       cfg_q;
    logic             bit_end;
    logic             frame_end;
    logic [2:0]       last_bit;

    // End of the current bit period and of the whole frame.
    always_comb begin
        bit_end   = tick && (sub == SUB_W'(OSR - 1));
        frame_end = (state == ST_STOP) && bit_end && (stop_idx == cfg_q.two_stop);
        last_bit  = {1'b0, cfg_q.len_sel} + 3'd4;
    end

    // Take a waiting byte when idle or right at the end of a frame.
    always_comb load = hold_full && ((state == ST_IDLE) || frame_end);

    // Line level for the current bit.
    always_comb begin
        unique case (state)
            ST_START: line = 1'b0;
            ST_DATA:  line = shreg[0];
            ST_PAR:   line = par_q;
            default:  line = 1'b1;
        endcase
    end

    always_comb busy = (state != ST_IDLE);

    // Frame sequencing, bit timing and data shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sub      <= '0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
            shreg    <= '0;
            par_q    <= 1'b0;
            cfg_q    <= '0;
        end else if (load) begin
            state    <= ST_START;
            sub      <= '0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
            shreg    <= keep_bits(hold_data, cfg.len_sel);
            par_q    <= parity_of(keep_bits(hold_data, cfg.len_sel), cfg);
            cfg_q    <= cfg;
        end else if (busy && tick) begin
            if (bit_end) begin
                sub <= '0;
                unique case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        shreg <= shreg >> 1;
                        if (bit_idx == last_bit) begin
                            bit_idx <= '0;
                            state   <= cfg_q.par_en ? ST_PAR : ST_STOP;
                        end else begin
                            bit_idx <= bit_idx + 3'd1;
                        end
                    end
                    ST_PAR: state <= ST_STOP;
                    ST_STOP: begin
                        if (stop_idx == cfg_q.two_stop)
                            state <= ST_IDLE;
                        else
                            stop_idx <= 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end else begin
                sub <= sub + SUB_W'(1);
            end
        end
    end

endmodule

// File: rtl/sertx_top.sv
// Serial transmitter top: ties the tick generator, holding register and
// frame shifter together and applies the break override to the line.
// Assumes synchronous active-low reset and a single clock domain.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OSR   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic [1:0]       cfg_len_sel,
    input  logic             cfg_two_stop,
    input  logic             cfg_par_en,
    input  logic             cfg_par_even,
    input  logic             cfg_par_stick,
    input  logic             line_break,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic             txd,
    output logic             hold_empty,
    output logic             tx_idle
);

    frame_cfg_t cfg;
    logic       tick;
    logic       load;
    logic       hold_full;
    logic [7:0] hold_data;
    logic       line;
    logic       busy;

    // Gather the format inputs.
    always_comb cfg = '{len_sel: cfg_len_sel, two_stop: cfg_two_stop,
                        par_en: cfg_par_en, par_even: cfg_par_even,
                        par_stick: cfg_par_stick};

    sertx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .restart (load),
        .tick    (tick)
    );

    sertx_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (load),
        .full    (hold_full),
        .data    (hold_data)
    );

    sertx_shifter #(.OSR(OSR)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cfg       (cfg),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .load      (load),
        .line      (line),
        .busy      (busy)
    );

    // Output line with break override, and status flags.
    always_comb begin
        txd        = line_break ? 1'b0 : line;
        hold_empty = ~hold_full;
        tx_idle    = ~busy & ~hold_full;
    end

endmodule

// File: rtl/sertx_chk.sv
// Checker: cycle-level properties relating the line and the status flags.
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic line_break,
    input logic txd,
    input logic hold_empty,
    input logic tx_idle
);

    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        line_break |-> !txd); // R8

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle && !line_break) |-> txd); // R1

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !hold_empty); // R2

    AST_IDLE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> hold_empty); // R9

    AST_START_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_idle) |=> (line_break || !txd)); // R3

endmodule

bind sertx_top sertx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .line_break (line_break),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_idle    (tx_idle)
);

// File: tb/sim_sertx_top.sv
module sim_sertx_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] divisor = 16'd1;
    logic [1:0]  cfg_len_sel = 2'd3;
    logic        cfg_two_stop = 1'b0;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_even = 1'b0;
    logic        cfg_par_stick = 1'b0;
    logic        line_break = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        txd, hold_empty, tx_idle;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Snapshot of the format used for the frame under test
    logic [7:0] s_b;
    logic [1:0] s_len;
    logic       s_two, s_pen, s_peven, s_pstick;
    int         s_div;

    sertx_top u0 (
        .clk(clk), .rst_n(rst_n), .divisor(divisor),
        .cfg_len_sel(cfg_len_sel), .cfg_two_stop(cfg_two_stop),
        .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_par_stick(cfg_par_stick), .line_break(line_break),
        .wr_en(wr_en), .wr_data(wr_data),
        .txd(txd), .hold_empty(hold_empty), .tx_idle(tx_idle)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic snap(input logic [7:0] b);
        s_b = b; s_len = cfg_len_sel; s_two = cfg_two_stop; s_pen = cfg_par_en;
        s_peven = cfg_par_even; s_pstick = cfg_par_stick; s_div = int'(divisor);
    endtask

    // Write a byte at idle; returns just after the load edge
    task automatic send(input logic [7:0] b);
        snap(b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        @(posedge clk); #1;
        check(hold_empty == 1'b0, "R2 hold full after write", hold_empty, 0);
        @(negedge clk); wr_en = 1'b0;
        @(posedge clk); #1;
        check(hold_empty && !tx_idle, "R2 loaded into shifter", {hold_empty, tx_idle}, 2'b10);
    endtask

    // Decode one frame starting at the load edge; skip = cycles already spent
    task automatic check_frame(input int skip, input bit more);
        int d, n, nb, ones;
        logic [11:0] expv, got;
        logic par;
        d = (s_div == 0) ? 1 : s_div;
        n = 5 + int'(s_len);
        nb = 1 + n + int'(s_pen) + 1 + int'(s_two);
        ones = 0;
        for (int i = 0; i < n; i++) ones += int'(s_b[i]);
        if (s_pstick) par = ~s_peven;
        else if (s_peven) par = ones[0];
        else par = ~ones[0];
        expv = '1;
        expv[0] = 1'b0;
        for (int i = 0; i < n; i++) expv[1+i] = s_b[i];
        if (s_pen) expv[1+n] = par;
        got = '1;
        repeat (8*d - skip) @(posedge clk);
        #1 got[0] = txd;
        for (int i = 1; i < nb; i++) begin
            repeat (16*d) @(posedge clk);
            #1 got[i] = txd;
        end
        // R3 R4 R5 R6 R7: whole frame against the computed one
        check(got == expv, "R3 R4 R5 R6 R7 frame bits", got, expv);
        repeat (8*d - 1) @(posedge clk); #1;
        check(tx_idle == 1'b0, "R9 busy until frame end", tx_idle, 0);
        @(posedge clk); #1;
        if (more)
            check(!txd && !tx_idle, "R10 next start without gap", {txd, tx_idle}, 0);
        else
            check(tx_idle && txd, "R9 idle at frame end", {tx_idle, txd}, 2'b11);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc >= 190000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected<190000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(txd && hold_empty && tx_idle, "R1 reset state", {txd, hold_empty, tx_idle}, 3'b111);

        // Sweep: length (R4) x parity mode (R6, R7) x stop count (R5) x data
        for (int l = 0; l < 4; l++)
            for (int pm = 0; pm < 5; pm++)
                for (int st = 0; st < 2; st++)
                    for (int p = 0; p < 4; p++) begin
                        @(negedge clk);
                        cfg_len_sel = 2'(l); cfg_two_stop = st[0];
                        cfg_par_en = (pm != 0);
                        cfg_par_stick = (pm >= 3);
                        cfg_par_even = (pm == 2) || (pm == 4);
                        send(pats[p]);
                        check_frame(0, 0);
                    end

        // R3: bit length scales with the divisor; 0 acts as 1
        @(negedge clk);
        cfg_len_sel = 2'd3; cfg_two_stop = 1'b0; cfg_par_en = 1'b1;
        cfg_par_stick = 1'b0; cfg_par_even = 1'b1;
        for (int dv = 0; dv < 4; dv++) begin
            @(negedge clk); divisor = 16'(dv);
            send(8'h96 + 8'(dv));
            check_frame(0, 0);
        end

        // R10: second byte written during a frame follows without gap
        @(negedge clk); divisor = 16'd2;
        send(8'h3C);
        @(negedge clk); wr_en = 1'b1; wr_data = 8'hC3;
        @(posedge clk); #1;
        check(hold_empty == 1'b0 && tx_idle == 1'b0, "R10 byte waits in holding", {hold_empty, tx_idle}, 0);
        @(negedge clk); wr_en = 1'b0;
        check_frame(1, 1);
        s_b = 8'hC3;
        check_frame(0, 0);

        // R11: format change during a frame leaves that frame unchanged
        @(negedge clk); divisor = 16'd1; cfg_len_sel = 2'd3; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
        send(8'hE7);
        @(negedge clk); cfg_len_sel = 2'd0; cfg_par_en = 1'b1; cfg_two_stop = 1'b1;
        check_frame(0, 0);
        send(8'hE7);
        check_frame(0, 0);

        // R8: break forces the line low at once and releases it
        @(negedge clk); line_break = 1'b1; #1;
        check(txd == 1'b0, "R8 break low", txd, 0);
        @(posedge clk); #1;
        check(txd == 1'b0, "R8 break held", txd, 0);
        @(negedge clk); line_break = 1'b0; #1;
        check(txd == 1'b1, "R8 break released", txd, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule